// File: doc/BRIEF.md
# Keyed Index/Data Configuration Window

This block gives a host a two-address configuration window into a multi-function peripheral chip. One address is an index port and the other is a data port, each eight bits wide. The window stays locked after reset. The host must write the key byte 0x87 to the index port on two consecutive index writes to open it. Writing 0xAA to the index port closes it again. While the window is open, the host writes a register number to the index port and then reads or writes that register through the data port.

Register 0x07 is global and holds a logical-device number. All registers from 0x30 upward belong to the bank of the device that number selects. Each bank holds an activate bit, two 16-bit I/O base addresses and an IRQ number. The block drives these values out as plain signals to the function blocks beside it. The power-event bank also holds a control register. Its top bit is a status flag: a hardware event pulse sets it, and the host clears it by writing a one to it.

Top module: `cfgw_top`

## Requirements
- R1: After reset the window is locked (`cfg_open` = 0) and every bank is inactive. Device 1 comes up with base 0x03F8 and IRQ 4, device 2 with base 0x02F8 and IRQ 3, and all other base and IRQ fields are 0.
- R2: The window opens only after two consecutive index-port writes of 0x87. Any other byte written to the index port between them sends the sequence back to its start.
- R3: An index-port write of 0xAA while open locks the window and leaves the index register unchanged.
- R4: While locked, data-port writes change no register and data-port reads return 0xFF.
- R5: Data register 0x07 holds the device number. Banks exist for devices 0x1, 0x2, 0x4, 0x5, 0x6, 0x7 and 0xA, which occupy output slots 0 to 6 in that order. With any other number selected, per-device reads return 0x00 and per-device writes are ignored.
- R6: Bit 0 of register 0x30 is the selected device's activate bit. It appears on `dev_active[slot]`.
- R7: Registers 0x60 and 0x61 are the high and low bytes of base 0. Registers 0x62 and 0x63 are the high and low bytes of base 1. Both bases appear on the slot's 16-bit output field.
- R8: Register 0x70 is the selected device's IRQ number. It appears on the slot's 8-bit IRQ field.
- R9: In device 0xA, register 0xFB bit 7 is a status flag. A `pwr_evt` pulse sets it. A data write with bit 7 = 1 clears it, and a write with bit 7 = 0 leaves it unchanged. Bits 6:0 are plain read/write storage, and `pwr_status` mirrors bit 7.
- R10: When a `pwr_evt` pulse and a clearing write fall in the same cycle, the flag ends set.
- R11: Reads of an unimplemented register number return 0x00.
- R12: An index-port read returns the current index register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | Host write strobe, one cycle per byte |
| io_rd | input | 1 | Host read strobe |
| io_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Read byte, valid while io_rd is high, 0 otherwise |
| pwr_evt | input | 1 | Power-event pulse that sets the status flag |
| cfg_open | output | 1 | Window is unlocked |
| dev_active | output | 7 | Activate bit per device slot |
| dev_base0 | output | 112 | First I/O base, 16 bits per slot |
| dev_base1 | output | 112 | Second I/O base, 16 bits per slot |
| dev_irq | output | 56 | IRQ number, 8 bits per slot |
| pwr_status | output | 1 | Power-event status flag |

## Verification
Two functions can meet in one cycle: the hardware event that sets the power status flag, and the host's write-one-to-clear of that flag. The bench drives a `pwr_evt` pulse in the same cycle as a data write of 0x80 to register 0xFB of device 0xA. It then expects `pwr_status` to stay at 1 and a read-back of 0xFB to show bit 7 set. Separate cycles with only the event, and with only the clear, confirm that each one works on its own.

// File: rtl/cfgw_pkg.sv
// Shared constants, reset tables and types for the configuration window.
// Assumes a fixed set of seven device banks whose order defines output slots.
package cfgw_pkg;

    localparam int DW       = 8;
    localparam int BASE_W   = 16;
    localparam int NUM_DEV  = 7;
    localparam int PWR_SLOT = 6;

    localparam logic [DW-1:0] KEY_BYTE  = 8'h87;
    localparam logic [DW-1:0] EXIT_BYTE = 8'hAA;
    localparam logic [DW-1:0] IDX_LDN   = 8'h07;
    localparam logic [DW-1:0] IDX_BANK0 = 8'h30;
    localparam logic [DW-1:0] IDX_ACT   = 8'h30;
    localparam logic [DW-1:0] IDX_B0H   = 8'h60;
    localparam logic [DW-1:0] IDX_B0L   = 8'h61;
    localparam logic [DW-1:0] IDX_B1H   = 8'h62;
    localparam logic [DW-1:0] IDX_B1L   = 8'h63;
    localparam logic [DW-1:0] IDX_IRQ   = 8'h70;
    localparam logic [DW-1:0] IDX_PWR   = 8'hFB;

    typedef enum logic [1:0] {
        LK_CLOSED = 2'd0,
        LK_HALF   = 2'd1,
        LK_OPEN   = 2'd2
    } lock_state_t;

    // Device number served by each output slot.
    function automatic logic [DW-1:0] slot_ldn(input int s);
        case (s)
            0:       return 8'h01;
            1:       return 8'h02;
            2:       return 8'h04;
            3:       return 8'h05;
            4:       return 8'h06;
            5:       return 8'h07;
            default: return 8'h0A;
        endcase
    endfunction

    // Reset value of the first base address per slot.
    function automatic logic [BASE_W-1:0] slot_base_rst(input int s);
        case (s)
            0:       return 16'h03F8;
            1:       return 16'h02F8;
            default: return 16'h0000;
        endcase
    endfunction

    // Reset value of the IRQ number per slot.
    function automatic logic [DW-1:0] slot_irq_rst(input int s);
        case (s)
            0:       return 8'd4;
            1:       return 8'd3;
            default: return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/cfgw_hostport.sv
// Host side of the window: key sequence tracker, index register, device
// selector and the qualified data-port write strobe for the banks.
// Assumes one io_wr pulse per byte; the index port is io_addr = 0.
module cfgw_hostport
    import cfgw_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_wr,
    input  logic          io_addr,
    input  logic [DW-1:0] io_wdata,
    output logic          cfg_open,
    output logic [DW-1:0] cur_idx,
    output logic [DW-1:0] cur_ldn,
    output logic          bank_wr
);

    lock_state_t   lk_q;
    logic          idx_wr;
    logic          dat_wr;
    logic [DW-1:0] idx_q;
    logic [DW-1:0] ldn_q;

    assign idx_wr = io_wr && !io_addr;
    assign dat_wr = io_wr &&  io_addr;

    // Key tracker: two back-to-back key bytes open, the exit byte closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_q <= LK_CLOSED;
        end else if (idx_wr) begin
            case (lk_q)
                LK_CLOSED: if (io_wdata == KEY_BYTE) lk_q <= LK_HALF;
                LK_HALF:   lk_q <= (io_wdata == KEY_BYTE) ? LK_OPEN : LK_CLOSED;
                LK_OPEN:   if (io_wdata == EXIT_BYTE) lk_q <= LK_CLOSED;
                default:   lk_q <= LK_CLOSED;
            endcase
        end
    end

    // Index register: loaded by index writes only while open, never by exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_wr && (lk_q == LK_OPEN) && (io_wdata != EXIT_BYTE)) begin
            idx_q <= io_wdata;
        end
    end

    // Device selector: global data register written while open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldn_q <= '0;
        end else if (dat_wr && (lk_q == LK_OPEN) && (idx_q == IDX_LDN)) begin
            ldn_q <= io_wdata;
        end
    end

    assign cfg_open = (lk_q == LK_OPEN);
    assign cur_idx  = idx_q;
    assign cur_ldn  = ldn_q;
    assign bank_wr  = dat_wr && (lk_q == LK_OPEN);

endmodule

// File: rtl/cfgw_bank.sv
// One logical-device register bank: activate bit, two bases, IRQ number and,
// for the power slot only, the control register with its sticky status flag.
// Assumes bank_wr is already qualified by the open window.
module cfgw_bank
    import cfgw_pkg::*;
#(
    parameter int SLOT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_wr,
    input  logic [DW-1:0]     cur_idx,
    input  logic [DW-1:0]     cur_ldn,
    input  logic [DW-1:0]     wdata,
    input  logic              pwr_evt,
    output logic              active,
    output logic [BASE_W-1:0] base0,
    output logic [BASE_W-1:0] base1,
    output logic [DW-1:0]     irq,
    output logic [DW-1:0]     rd_val,
    output logic              pwr_flag
);

    localparam logic [DW-1:0]     MY_LDN   = slot_ldn(SLOT);
    localparam logic [BASE_W-1:0] BASE_RST = slot_base_rst(SLOT);
    localparam logic [DW-1:0]     IRQ_RST  = slot_irq_rst(SLOT);
    localparam bit                HAS_PWR  = (SLOT == PWR_SLOT);

    logic              wr;
    logic              act_q;
    logic [BASE_W-1:0] b0_q;
    logic [BASE_W-1:0] b1_q;
    logic [DW-1:0]     irq_q;
    logic [DW-2:0]     ctl_lo;
    logic              flag_q;

    assign wr = bank_wr && (cur_ldn == MY_LDN);

    // Activate bit and IRQ number storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            irq_q <= IRQ_RST;
        end else if (wr) begin
            if (cur_idx == IDX_ACT) act_q <= wdata[0];
            if (cur_idx == IDX_IRQ) irq_q <= wdata;
        end
    end

    // Base address storage, one byte lane per index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b0_q <= BASE_RST;
            b1_q <= '0;
        end else if (wr) begin
            case (cur_idx)
                IDX_B0H: b0_q[BASE_W-1:DW] <= wdata;
                IDX_B0L: b0_q[DW-1:0]      <= wdata;
                IDX_B1H: b1_q[BASE_W-1:DW] <= wdata;
                IDX_B1L: b1_q[DW-1:0]      <= wdata;
                default: ;
            endcase
        end
    end

    generate
        if (HAS_PWR) begin : g_pwr
            // Control low bits: plain read/write storage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ctl_lo <= '0;
                end else if (wr && (cur_idx == IDX_PWR)) begin
                    ctl_lo <= wdata[DW-2:0];
                end
            end

            // Status flag: event sets, a written one clears, event wins a tie.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag_q <= 1'b0;
                end else if (pwr_evt) begin
                    flag_q <= 1'b1;
                end else if (wr && (cur_idx == IDX_PWR) && wdata[DW-1]) begin
                    flag_q <= 1'b0;
                end
            end
        end else begin : g_nopwr
            logic unused_evt;
            assign unused_evt = pwr_evt;
            assign ctl_lo     = '0;
            assign flag_q     = 1'b0;
        end
    endgenerate

    // Read-back value for the current index.
    always_comb begin
        case (cur_idx)
            IDX_ACT: rd_val = {{(DW-1){1'b0}}, act_q};
            IDX_B0H: rd_val = b0_q[BASE_W-1:DW];
            IDX_B0L: rd_val = b0_q[DW-1:0];
            IDX_B1H: rd_val = b1_q[BASE_W-1:DW];
            IDX_B1L: rd_val = b1_q[DW-1:0];
            IDX_IRQ: rd_val = irq_q;
            IDX_PWR: rd_val = HAS_PWR ? {flag_q, ctl_lo} : '0;
            default: rd_val = '0;
        endcase
    end

    assign active   = act_q;
    assign base0    = b0_q;
    assign base1    = b1_q;
    assign irq      = irq_q;
    assign pwr_flag = flag_q;

endmodule

// File: rtl/cfgw_rdmux.sv
// Read path: chooses between index register, locked pattern, the global
// selector and the selected bank's value. Purely combinational.
// Assumes bank values arrive packed by slot.
module cfgw_rdmux
    import cfgw_pkg::*;
(
    input  logic                  io_rd,
    input  logic                  io_addr,
    input  logic                  cfg_open,
    input  logic [DW-1:0]         cur_idx,
    input  logic [DW-1:0]         cur_ldn,
    input  logic [NUM_DEV*DW-1:0] bank_rd,
    output logic [DW-1:0]         io_rdata
);

    // Priority selection of the byte returned to the host.
    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            if (!io_addr) begin
                io_rdata = cur_idx;
            end else if (!cfg_open) begin
                io_rdata = '1;
            end else if (cur_idx == IDX_LDN) begin
                io_rdata = cur_ldn;
            end else if (cur_idx >= IDX_BANK0) begin
                for (int s = 0; s < NUM_DEV; s++) begin
                    if (cur_ldn == slot_ldn(s)) io_rdata = bank_rd[s*DW +: DW];
                end
            end
        end
    end

endmodule

// File: rtl/cfgw_top.sv
// Keyed index/data configuration window with banked per-device registers.
// Assumes a single host master; outputs feed the chip's function blocks.
module cfgw_top
    import cfgw_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      io_wr,
    input  logic                      io_rd,
    input  logic                      io_addr,
    input  logic [DW-1:0]             io_wdata,
    output logic [DW-1:0]             io_rdata,
    input  logic                      pwr_evt,
    output logic                      cfg_open,
    output logic [NUM_DEV-1:0]        dev_active,
    output logic [NUM_DEV*BASE_W-1:0] dev_base0,
    output logic [NUM_DEV*BASE_W-1:0] dev_base1,
    output logic [NUM_DEV*DW-1:0]     dev_irq,
    output logic                      pwr_status
);

    logic [DW-1:0]         cur_idx;
    logic [DW-1:0]         cur_ldn;
    logic                  bank_wr;
    logic [NUM_DEV*DW-1:0] bank_rd;
    logic [NUM_DEV-1:0]    flag_vec;

    cfgw_hostport u_host (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .cfg_open (cfg_open),
        .cur_idx  (cur_idx),
        .cur_ldn  (cur_ldn),
        .bank_wr  (bank_wr)
    );

    generate
        for (genvar s = 0; s < NUM_DEV; s++) begin : g_bank
            cfgw_bank #(.SLOT(s)) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .bank_wr  (bank_wr),
                .cur_idx  (cur_idx),
                .cur_ldn  (cur_ldn),
                .wdata    (io_wdata),
                .pwr_evt  (pwr_evt),
                .active   (dev_active[s]),
                .base0    (dev_base0[s*BASE_W +: BASE_W]),
                .base1    (dev_base1[s*BASE_W +: BASE_W]),
                .irq      (dev_irq[s*DW +: DW]),
                .rd_val   (bank_rd[s*DW +: DW]),
                .pwr_flag (flag_vec[s])
            );
        end
    endgenerate

    cfgw_rdmux u_rd (
        .io_rd    (io_rd),
        .io_addr  (io_addr),
        .cfg_open (cfg_open),
        .cur_idx  (cur_idx),
        .cur_ldn  (cur_ldn),
        .bank_rd  (bank_rd),
        .io_rdata (io_rdata)
    );

    assign pwr_status = |flag_vec;

endmodule

// File: rtl/cfgw_top_chk.sv
// Port-level protocol checks for cfgw_top, attached by bind below.
module cfgw_top_chk
    import cfgw_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic                      io_wr,
    input logic                      io_rd,
    input logic                      io_addr,
    input logic [DW-1:0]             io_wdata,
    input logic [DW-1:0]             io_rdata,
    input logic                      pwr_evt,
    input logic                      cfg_open,
    input logic [NUM_DEV-1:0]        dev_active,
    input logic [NUM_DEV*BASE_W-1:0] dev_base0,
    input logic [NUM_DEV*BASE_W-1:0] dev_base1,
    input logic [NUM_DEV*DW-1:0]     dev_irq,
    input logic                      pwr_status
);

    p_open_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(io_wr && !io_addr && (io_wdata == KEY_BYTE)));

    p_exit_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && io_wr && !io_addr && (io_wdata == EXIT_BYTE)) |=> !cfg_open);

    p_locked_reads_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_rd && io_addr) |-> (io_rdata == 8'hFF));

    p_locked_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_wr && io_addr) |=>
            ($stable(dev_active) && $stable(dev_base0) &&
             $stable(dev_base1) && $stable(dev_irq)));

    p_status_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_evt && !(io_wr && io_addr)) |=> $stable(pwr_status));

    p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_evt |=> pwr_status);

endmodule

bind cfgw_top cfgw_top_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_addr    (io_addr),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .pwr_evt    (pwr_evt),
    .cfg_open   (cfg_open),
    .dev_active (dev_active),
    .dev_base0  (dev_base0),
    .dev_base1  (dev_base1),
    .dev_irq    (dev_irq),
    .pwr_status (pwr_status)
);

// File: tb/cfgw_top_tb.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor compares them.
module cfgw_top_tb;
    import cfgw_pkg::*;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      io_wr = 1'b0;
    logic                      io_rd = 1'b0;
    logic                      io_addr = 1'b0;
    logic [DW-1:0]             io_wdata = '0;
    logic [DW-1:0]             io_rdata;
    logic                      pwr_evt = 1'b0;
    logic                      cfg_open;
    logic [NUM_DEV-1:0]        dev_active;
    logic [NUM_DEV*BASE_W-1:0] dev_base0;
    logic [NUM_DEV*BASE_W-1:0] dev_base1;
    logic [NUM_DEV*DW-1:0]     dev_irq;
    logic                      pwr_status;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #5 clk = ~clk;

    cfgw_top u_dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .pwr_evt(pwr_evt), .cfg_open(cfg_open), .dev_active(dev_active),
        .dev_base0(dev_base0), .dev_base1(dev_base1), .dev_irq(dev_irq),
        .pwr_status(pwr_status)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pop and compare one expected byte per read cycle.
    always @(negedge clk) begin
        if (io_rd) begin
            if (exp_q.size() == 0) begin
                check(32'(io_rdata), 32'hDEAD, "unexpected read");
            end else begin
                check(32'(io_rdata), 32'(exp_q.pop_front()), tag_q.pop_front());
            end
        end
    end

    task automatic wr(input logic a, input logic [7:0] d, input logic evt);
        @(posedge clk); #1;
        io_wr = 1'b1; io_addr = a; io_wdata = d; pwr_evt = evt;
        @(posedge clk); #1;
        io_wr = 1'b0; pwr_evt = 1'b0;
    endtask

    task automatic rd(input logic a, input logic [7:0] exp, input string req);
        @(posedge clk); #1;
        exp_q.push_back(exp); tag_q.push_back(req);
        io_rd = 1'b1; io_addr = a;
        @(posedge clk); #1;
        io_rd = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
        wr(1'b0, idx, 1'b0);
        wr(1'b1, d, 1'b0);
    endtask

    task automatic reg_rd(input logic [7:0] idx, input logic [7:0] exp, input string req);
        wr(1'b0, idx, 1'b0);
        rd(1'b1, exp, req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check(32'(cfg_open), 0, "R1 locked");
        check(32'(dev_active), 0, "R1 inactive");
        check(32'(dev_base0[0 +: 16]), 32'h03F8, "R1 dev1 base");
        check(32'(dev_base0[16 +: 16]), 32'h02F8, "R1 dev2 base");
        check(32'(dev_irq[0 +: 8]), 4, "R1 dev1 irq");
        check(32'(dev_irq[8 +: 8]), 3, "R1 dev2 irq");
        rd(1'b1, 8'hFF, "R4 locked read");

        // R4 locked data write ignored
        wr(1'b1, 8'h01, 1'b0);
        check(32'(dev_active), 0, "R4 locked write");

        // R2 broken key restarts, then proper key opens
        wr(1'b0, 8'h87, 1'b0);
        wr(1'b0, 8'h12, 1'b0);
        wr(1'b0, 8'h87, 1'b0);
        check(32'(cfg_open), 0, "R2 broken key");
        wr(1'b0, 8'h87, 1'b0);
        check(32'(cfg_open), 1, "R2 open");

        // R5 / R12 select device 1
        reg_wr(8'h07, 8'h01);
        rd(1'b0, 8'h07, "R12 index read");
        rd(1'b1, 8'h01, "R5 ldn read");
        reg_rd(8'h60, 8'h03, "R7 base hi reset");
        reg_rd(8'h61, 8'hF8, "R7 base lo reset");
        reg_rd(8'h70, 8'h04, "R8 irq reset");

        // R6 R7 R8 programming
        reg_wr(8'h60, 8'h12);
        reg_wr(8'h61, 8'h34);
        reg_wr(8'h62, 8'hAB);
        reg_wr(8'h63, 8'hCD);
        reg_wr(8'h70, 8'h07);
        reg_wr(8'h30, 8'h01);
        check(32'(dev_base0[0 +: 16]), 32'h1234, "R7 base0 out");
        check(32'(dev_base1[0 +: 16]), 32'hABCD, "R7 base1 out");
        check(32'(dev_irq[0 +: 8]), 7, "R8 irq out");
        check(32'(dev_active), 32'h01, "R6 active out");
        reg_rd(8'h30, 8'h01, "R6 readback");
        reg_rd(8'h63, 8'hCD, "R7 readback");

        // R5 bank separation on device 2
        reg_wr(8'h07, 8'h02);
        reg_rd(8'h60, 8'h02, "R5 dev2 bank");
        reg_wr(8'h30, 8'h01);
        check(32'(dev_active), 32'h03, "R6 dev2 active");

        // R5 unknown device number
        reg_wr(8'h07, 8'h03);
        reg_wr(8'h30, 8'h01);
        check(32'(dev_active), 32'h03, "R5 unknown write");
        reg_rd(8'h30, 8'h00, "R5 unknown read");

        // R11 unimplemented registers
        reg_wr(8'h07, 8'h01);
        reg_rd(8'h45, 8'h00, "R11 bank hole");
        reg_rd(8'h20, 8'h00, "R11 global hole");

        // R9 power bank flag
        reg_wr(8'h07, 8'h0A);
        wr(1'b0, 8'hFB, 1'b1);
        check(32'(pwr_status), 1, "R9 event sets");
        rd(1'b1, 8'h80, "R9 flag read");
        wr(1'b1, 8'h05, 1'b0);
        check(32'(pwr_status), 1, "R9 zero keeps");
        rd(1'b1, 8'h85, "R9 low bits");
        wr(1'b1, 8'h80, 1'b0);
        check(32'(pwr_status), 0, "R9 w1c");
        rd(1'b1, 8'h00, "R9 after clear");

        // R10 event and clear together
        wr(1'b1, 8'h80, 1'b1);
        check(32'(pwr_status), 1, "R10 event wins");
        rd(1'b1, 8'h80, "R10 readback");

        // R5 clear via wrong bank ignored
        reg_wr(8'h07, 8'h01);
        reg_wr(8'hFB, 8'h80);
        check(32'(pwr_status), 1, "R5 wrong bank w1c");

        // R3 exit
        wr(1'b0, 8'h30, 1'b0);
        wr(1'b0, 8'hAA, 1'b0);
        check(32'(cfg_open), 0, "R3 exit");
        rd(1'b0, 8'h30, "R3 index kept");
        rd(1'b1, 8'hFF, "R4 locked after exit");
        wr(1'b1, 8'h00, 1'b0);
        check(32'(dev_active), 32'h03, "R4 locked write after exit");

        repeat (3) @(posedge clk);
        check(32'(exp_q.size()), 0, "scoreboard drained");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule